// File: doc/BRIEF.md
# Control Endpoint Stage Sequencer

This block steers endpoint zero through the phases of a USB control transfer. It works on token events that an upstream packet engine has already decoded: a setup packet with its request fields, an OUT data token, an IN token, and a status-phase token. For every token it registers a handshake decision one clock later. Inside the block, each incoming request is either finished by built-in logic or handed to the CPU through an interrupt flag. Standard descriptor reads and writes, and every non-standard request, go to the CPU.

Once a request reaches the CPU, the data phase is assumed to run from host to device. The first IN token that arrives instead is refused with NACK, and that token flips the direction bit. Software may also flip the direction ahead of time so that the first IN token succeeds at once. The status phase is acknowledged only after software has armed it. A setup packet arriving at any point aborts the current transfer and restarts it.

Top module: `ep0_stage_seq`

## Requirements
- R1: A setup packet is always acknowledged. It clears `dir_in`, `data_pend`, `rx_full`, `tx_full` and `stat_en`. It sets `setup_irq` only when it is passed to the CPU, which happens when `setup_std`=0 or the request code is 6 or 7.
- R2: After reset, all outputs are 0 and `stage` is 0 (idle). Each cycle carrying a token strobe is followed, one clock later, by exactly one of `hs_ack` or `hs_nack`. A cycle with no token is followed by neither.
- R3: A standard request with code 9 and value greater than NUM_CFG, or with code 11 and value of NUM_ALT or more, is finished internally. It also raises `req_val_evt` for one cycle, one clock after the setup strobe.
- R4: In the data stage (`stage`=1) with `dir_in`=0, an OUT token is acknowledged when `rx_full`=0 and then sets `rx_full` and `data_pend`. An OUT token arriving while `rx_full`=1 gets NACK.
- R5: In the data stage with `dir_in`=0, an IN token gets NACK and sets both `dir_in` and `data_pend`.
- R6: In the data stage, a `cpu_dir_preset` strobe sets `dir_in` and `data_pend`. With `dir_in`=1, an IN token is acknowledged if `tx_full`=1, which clears `tx_full` and sets `data_pend`; otherwise it gets NACK.
- R7: In the data stage, `cpu_buf_done` clears `data_pend`. It also clears `rx_full` when `dir_in`=0 and sets `tx_full` when `dir_in`=1.
- R8: In the data or status stage, a status token with `stat_en`=0 gets NACK and sets `stat_irq`. With `stat_en`=1, the status token is acknowledged, `stat_en` clears and `stage` returns to 0.
- R9: A setup packet arriving in any stage restarts the sequence. `stat_en` reads 0 afterwards, even if `cpu_stat_enable` was strobed in the same cycle.
- R10: `setup_irq` and `stat_irq` stay set until their clear strobes. When a set and a clear arrive in the same cycle, the set wins.
- R11: A CPU request with `setup_nodata`=1 moves straight to the status stage (`stage`=2), where OUT and IN tokens get NACK.
- R12: A request finished internally enters `stage`=3. There, OUT, IN and status tokens are all acknowledged, the status token returns `stage` to 0, and `setup_irq` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| setup_stb | input | 1 | Setup packet received |
| setup_std | input | 1 | Request type is standard |
| setup_req | input | REQ_W | Request code |
| setup_val | input | VAL_W | Low byte of request value |
| setup_nodata | input | 1 | Request length is zero |
| out_stb | input | 1 | OUT data token |
| in_stb | input | 1 | IN data token |
| stat_stb | input | 1 | Status-phase token |
| cpu_dir_preset | input | 1 | Software forces IN direction |
| cpu_stat_enable | input | 1 | Software arms status acknowledge |
| cpu_setup_irq_clr | input | 1 | Clear setup interrupt flag |
| cpu_stat_irq_clr | input | 1 | Clear status interrupt flag |
| cpu_buf_done | input | 1 | CPU consumed OUT data or loaded IN data |
| hs_ack | output | 1 | Handshake: ACK |
| hs_nack | output | 1 | Handshake: NACK |
| dir_in | output | 1 | Data direction, 1 = device to host |
| data_pend | output | 1 | CPU service of the buffer is pending |
| rx_full | output | 1 | Received OUT data awaits the CPU |
| tx_full | output | 1 | IN data loaded by the CPU |
| setup_irq | output | 1 | Setup interrupt flag |
| stat_irq | output | 1 | Status interrupt flag |
| stat_en | output | 1 | Status acknowledge armed |
| req_val_evt | output | 1 | Unsupported configuration or alternate setting seen |
| stage | output | 2 | 0 idle, 1 data, 2 status, 3 internal |

## Verification
The properties assume that at most one token strobe is active per cycle, and that a setup strobe takes priority when a conflict occurs. They also assume that software strobes follow the stage rules and do not change the decision on a token arriving in the same cycle. The stimulus respects this: it issues each token on its own, with an idle cycle between tokens, and it keeps CPU strobes apart from tokens. The only exception is a set-versus-clear overlap, driven on purpose to show that the set wins. A sweep runs every request code against several value bytes, with both type settings, and computes the routing and the event flag arithmetically.

// File: rtl/ep0_pkg.sv
package ep0_pkg;
    typedef enum logic [1:0] {
        STG_IDLE   = 2'd0,
        STG_DATA   = 2'd1,
        STG_STATUS = 2'd2,
        STG_AUTO   = 2'd3
    } stage_e;

    localparam int REQ_GET_DESC = 6;
    localparam int REQ_SET_DESC = 7;
    localparam int REQ_SET_CFG  = 9;
    localparam int REQ_SET_IF   = 11;

    typedef struct packed {
        stage_e stage;
        logic   dir_in;
        logic   data_pend;
        logic   rx_full;
        logic   tx_full;
        logic   arm;
        logic   ack;
        logic   nack;
        logic   evt;
    } seq_state_t;

    typedef struct packed {
        logic setup_flag;
        logic stat_flag;
    } irq_state_t;
endpackage

// File: rtl/ep0_req_decode.sv
module ep0_req_decode #(
    parameter int REQ_W   = 8,
    parameter int VAL_W   = 8,
    parameter int NUM_CFG = 1,
    parameter int NUM_ALT = 1
) (
    input  logic             is_std,
    input  logic [REQ_W-1:0] req,
    input  logic [VAL_W-1:0] val,
    output logic             to_cpu,
    output logic             odd_value
);
    import ep0_pkg::*;

    logic is_desc;
    logic bad_cfg;
    logic bad_alt;

    always_comb begin
        is_desc   = (req == REQ_W'(REQ_GET_DESC)) || (req == REQ_W'(REQ_SET_DESC));
        bad_cfg   = (req == REQ_W'(REQ_SET_CFG)) && (val > VAL_W'(NUM_CFG));
        bad_alt   = (req == REQ_W'(REQ_SET_IF))  && (val >= VAL_W'(NUM_ALT));
        to_cpu    = !is_std || is_desc;
        odd_value = is_std && (bad_cfg || bad_alt);
    end
endmodule

// File: rtl/ep0_irq_flags.sv
module ep0_irq_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_setup,
    input  logic clr_setup,
    input  logic set_stat,
    input  logic clr_stat,
    output logic setup_flag,
    output logic stat_flag
);
    import ep0_pkg::*;

    irq_state_t irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        if (clr_setup) irq_d.setup_flag = 1'b0;
        if (set_setup) irq_d.setup_flag = 1'b1;
        if (clr_stat)  irq_d.stat_flag  = 1'b0;
        if (set_stat)  irq_d.stat_flag  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign setup_flag = irq_q.setup_flag;
    assign stat_flag  = irq_q.stat_flag;
endmodule

// File: rtl/ep0_stage_ctrl.sv
module ep0_stage_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       setup_stb,
    input  logic       req_to_cpu,
    input  logic       req_odd,
    input  logic       nodata,
    input  logic       out_stb,
    input  logic       in_stb,
    input  logic       stat_stb,
    input  logic       preset_in,
    input  logic       arm_status,
    input  logic       buf_done,
    output logic       raise_setup,
    output logic       raise_stat,
    output logic       ack,
    output logic       nack,
    output logic       evt,
    output logic       dir_in,
    output logic       data_pend,
    output logic       rx_full,
    output logic       tx_full,
    output logic       arm,
    output logic [1:0] stage
);
    import ep0_pkg::*;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.ack    = 1'b0;
        st_d.nack   = 1'b0;
        st_d.evt    = 1'b0;
        raise_setup = 1'b0;
        raise_stat  = 1'b0;

        if (arm_status) st_d.arm = 1'b1;

        if (preset_in && st_q.stage == STG_DATA) begin
            st_d.dir_in    = 1'b1;
            st_d.data_pend = 1'b1;
        end

        if (buf_done && st_q.stage == STG_DATA) begin
            st_d.data_pend = 1'b0;
            if (st_q.dir_in) st_d.tx_full = 1'b1;
            else             st_d.rx_full = 1'b0;
        end

        if (setup_stb) begin
            st_d.ack       = 1'b1;
            st_d.arm       = 1'b0;
            st_d.dir_in    = 1'b0;
            st_d.data_pend = 1'b0;
            st_d.rx_full   = 1'b0;
            st_d.tx_full   = 1'b0;
            st_d.evt       = req_odd;
            if (req_to_cpu) begin
                raise_setup = 1'b1;
                st_d.stage  = nodata ? STG_STATUS : STG_DATA;
            end else begin
                st_d.stage  = STG_AUTO;
            end
        end else if (out_stb) begin
            unique case (st_q.stage)
                STG_DATA: begin
                    if (!st_q.dir_in && !st_q.rx_full) begin
                        st_d.ack       = 1'b1;
                        st_d.rx_full   = 1'b1;
                        st_d.data_pend = 1'b1;
                    end else begin
                        st_d.nack = 1'b1;
                    end
                end
                STG_AUTO: st_d.ack  = 1'b1;
                default:  st_d.nack = 1'b1;
            endcase
        end else if (in_stb) begin
            unique case (st_q.stage)
                STG_DATA: begin
                    if (!st_q.dir_in) begin
                        st_d.nack      = 1'b1;
                        st_d.dir_in    = 1'b1;
                        st_d.data_pend = 1'b1;
                    end else if (st_q.tx_full) begin
                        st_d.ack       = 1'b1;
                        st_d.tx_full   = 1'b0;
                        st_d.data_pend = 1'b1;
                    end else begin
                        st_d.nack = 1'b1;
                    end
                end
                STG_AUTO: st_d.ack  = 1'b1;
                default:  st_d.nack = 1'b1;
            endcase
        end else if (stat_stb) begin
            unique case (st_q.stage)
                STG_DATA, STG_STATUS: begin
                    if (st_q.arm) begin
                        st_d.ack   = 1'b1;
                        st_d.arm   = 1'b0;
                        st_d.stage = STG_IDLE;
                    end else begin
                        st_d.nack  = 1'b1;
                        raise_stat = 1'b1;
                    end
                end
                STG_AUTO: begin
                    st_d.ack   = 1'b1;
                    st_d.stage = STG_IDLE;
                end
                default: st_d.nack = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{stage: STG_IDLE, default: '0};
        else        st_q <= st_d;
    end

    assign ack       = st_q.ack;
    assign nack      = st_q.nack;
    assign evt       = st_q.evt;
    assign dir_in    = st_q.dir_in;
    assign data_pend = st_q.data_pend;
    assign rx_full   = st_q.rx_full;
    assign tx_full   = st_q.tx_full;
    assign arm       = st_q.arm;
    assign stage     = st_q.stage;
endmodule

// File: rtl/ep0_stage_seq.sv
module ep0_stage_seq #(
    parameter int REQ_W   = 8,
    parameter int VAL_W   = 8,
    parameter int NUM_CFG = 1,
    parameter int NUM_ALT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             setup_stb,
    input  logic             setup_std,
    input  logic [REQ_W-1:0] setup_req,
    input  logic [VAL_W-1:0] setup_val,
    input  logic             setup_nodata,
    input  logic             out_stb,
    input  logic             in_stb,
    input  logic             stat_stb,
    input  logic             cpu_dir_preset,
    input  logic             cpu_stat_enable,
    input  logic             cpu_setup_irq_clr,
    input  logic             cpu_stat_irq_clr,
    input  logic             cpu_buf_done,
    output logic             hs_ack,
    output logic             hs_nack,
    output logic             dir_in,
    output logic             data_pend,
    output logic             rx_full,
    output logic             tx_full,
    output logic             setup_irq,
    output logic             stat_irq,
    output logic             stat_en,
    output logic             req_val_evt,
    output logic [1:0]       stage
);
    logic to_cpu;
    logic odd_value;
    logic raise_setup;
    logic raise_stat;

    ep0_req_decode #(
        .REQ_W  (REQ_W),
        .VAL_W  (VAL_W),
        .NUM_CFG(NUM_CFG),
        .NUM_ALT(NUM_ALT)
    ) u_decode (
        .is_std   (setup_std),
        .req      (setup_req),
        .val      (setup_val),
        .to_cpu   (to_cpu),
        .odd_value(odd_value)
    );

    ep0_stage_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .setup_stb  (setup_stb),
        .req_to_cpu (to_cpu),
        .req_odd    (odd_value),
        .nodata     (setup_nodata),
        .out_stb    (out_stb),
        .in_stb     (in_stb),
        .stat_stb   (stat_stb),
        .preset_in  (cpu_dir_preset),
        .arm_status (cpu_stat_enable),
        .buf_done   (cpu_buf_done),
        .raise_setup(raise_setup),
        .raise_stat (raise_stat),
        .ack        (hs_ack),
        .nack       (hs_nack),
        .evt        (req_val_evt),
        .dir_in     (dir_in),
        .data_pend  (data_pend),
        .rx_full    (rx_full),
        .tx_full    (tx_full),
        .arm        (stat_en),
        .stage      (stage)
    );

    ep0_irq_flags u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_setup (raise_setup),
        .clr_setup (cpu_setup_irq_clr),
        .set_stat  (raise_stat),
        .clr_stat  (cpu_stat_irq_clr),
        .setup_flag(setup_irq),
        .stat_flag (stat_irq)
    );
endmodule

// File: rtl/ep0_stage_seq_chk.sv
module ep0_stage_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       setup_stb,
    input logic       out_stb,
    input logic       in_stb,
    input logic       stat_stb,
    input logic       hs_ack,
    input logic       hs_nack,
    input logic       dir_in,
    input logic       data_pend,
    input logic       rx_full,
    input logic       tx_full,
    input logic       stat_irq,
    input logic       stat_en,
    input logic       req_val_evt,
    input logic [1:0] stage
);
    logic any_tok;
    assign any_tok = setup_stb | out_stb | in_stb | stat_stb;

    // R2
    one_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_tok |=> (hs_ack ^ hs_nack));

    // R2
    quiet_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_tok |=> (!hs_ack && !hs_nack));

    // R1
    setup_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        setup_stb |=> (hs_ack && !dir_in && !data_pend && !rx_full && !tx_full));

    // R9
    setup_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        setup_stb |=> !stat_en);

    // R3
    evt_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_val_evt |-> $past(setup_stb));

    // R5
    in_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stb && !setup_stb && stage == 2'd1 && !dir_in) |=> (hs_nack && dir_in && data_pend));

    // R8
    status_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_stb && !setup_stb && !stat_en && (stage == 2'd1 || stage == 2'd2))
        |=> (hs_nack && stat_irq));

    // R11
    status_data_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_stb || in_stb) && !setup_stb && stage == 2'd2) |=> hs_nack);

    // R12
    auto_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_stb || in_stb || stat_stb) && !setup_stb && stage == 2'd3) |=> hs_ack);
endmodule

bind ep0_stage_seq ep0_stage_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .setup_stb  (setup_stb),
    .out_stb    (out_stb),
    .in_stb     (in_stb),
    .stat_stb   (stat_stb),
    .hs_ack     (hs_ack),
    .hs_nack    (hs_nack),
    .dir_in     (dir_in),
    .data_pend  (data_pend),
    .rx_full    (rx_full),
    .tx_full    (tx_full),
    .stat_irq   (stat_irq),
    .stat_en    (stat_en),
    .req_val_evt(req_val_evt),
    .stage      (stage)
);

// File: tb/ep0_stage_seq_tb.sv
module ep0_stage_seq_tb;
    localparam int NCFG = 1;
    localparam int NALT = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic setup_stb = 0, setup_std = 0, setup_nodata = 0;
    logic [7:0] setup_req = '0, setup_val = '0;
    logic out_stb = 0, in_stb = 0, stat_stb = 0;
    logic cpu_dir_preset = 0, cpu_stat_enable = 0, cpu_setup_irq_clr = 0;
    logic cpu_stat_irq_clr = 0, cpu_buf_done = 0;
    logic hs_ack, hs_nack, dir_in, data_pend, rx_full, tx_full;
    logic setup_irq, stat_irq, stat_en, req_val_evt;
    logic [1:0] stage;

    int nvec = 0;
    int nbad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    ep0_stage_seq #(.NUM_CFG(NCFG), .NUM_ALT(NALT)) u_dut (.*);

    task automatic chk(string req, int act, int exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // kind: 0 out, 1 in, 2 status
    task automatic tok(int kind);
        @(negedge clk);
        out_stb  = (kind == 0);
        in_stb   = (kind == 1);
        stat_stb = (kind == 2);
        @(negedge clk);
        out_stb = 0; in_stb = 0; stat_stb = 0;
    endtask

    task automatic setup(bit std, int req, int val, bit nod);
        @(negedge clk);
        setup_stb = 1; setup_std = std; setup_req = 8'(req);
        setup_val = 8'(val); setup_nodata = nod;
        @(negedge clk);
        setup_stb = 0;
    endtask

    // kind: 0 preset, 1 arm status, 2 clr setup irq, 3 clr stat irq, 4 buf done
    task automatic cpu(int kind);
        @(negedge clk);
        cpu_dir_preset    = (kind == 0);
        cpu_stat_enable   = (kind == 1);
        cpu_setup_irq_clr = (kind == 2);
        cpu_stat_irq_clr  = (kind == 3);
        cpu_buf_done      = (kind == 4);
        @(negedge clk);
        cpu_dir_preset = 0; cpu_stat_enable = 0; cpu_setup_irq_clr = 0;
        cpu_stat_irq_clr = 0; cpu_buf_done = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nbad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R2 reset state
        chk("R2 stage", int'(stage), 0);
        chk("R2 ack", int'(hs_ack), 0);
        chk("R2 nack", int'(hs_nack), 0);
        chk("R2 flags", int'({dir_in, data_pend, rx_full, tx_full, setup_irq, stat_irq, stat_en}), 0);
        tok(0);
        chk("R2 idle out nack", int'(hs_nack), 1);
        chk("R2 idle out ack", int'(hs_ack), 0);

        // R1 R3 R12 sweep over request space
        for (int s = 0; s < 2; s++) begin
            for (int r = 0; r < 16; r++) begin
                for (int v = 0; v < 4; v++) begin
                    bit fwd, odd;
                    fwd = (s == 0) || r == 6 || r == 7;
                    odd = (s == 1) && ((r == 9 && v > NCFG) || (r == 11 && v >= NALT));
                    cpu(2);
                    setup(s[0], r, v, v[0]);
                    chk("R1 setup ack", int'(hs_ack), 1);
                    chk("R1 setup irq", int'(setup_irq), int'(fwd));
                    chk("R3 value event", int'(req_val_evt), int'(odd));
                    chk("R11 R12 stage", int'(stage), fwd ? (v[0] ? 2 : 1) : 3);
                    if (fwd) cpu(1);
                    tok(2);
                    chk("R8 R12 status ack", int'(hs_ack), 1);
                    chk("R8 R12 back to idle", int'(stage), 0);
                    chk("R3 event one cycle", int'(req_val_evt), 0);
                end
            end
        end

        // OUT data stage
        cpu(2);
        setup(1, 6, 0, 0);
        chk("R1 dir cleared", int'(dir_in), 0);
        tok(0);
        chk("R4 out ack", int'(hs_ack), 1);
        chk("R4 rx_full", int'(rx_full), 1);
        chk("R4 data_pend", int'(data_pend), 1);
        tok(0);
        chk("R4 out busy nack", int'(hs_nack), 1);
        cpu(4);
        chk("R7 rx cleared", int'(rx_full), 0);
        chk("R7 pend cleared", int'(data_pend), 0);
        // IN correction
        tok(1);
        chk("R5 in nack", int'(hs_nack), 1);
        chk("R5 dir flipped", int'(dir_in), 1);
        chk("R5 pend set", int'(data_pend), 1);
        tok(1);
        chk("R6 in empty nack", int'(hs_nack), 1);
        cpu(4);
        chk("R7 tx loaded", int'(tx_full), 1);
        chk("R7 pend cleared in", int'(data_pend), 0);
        tok(1);
        chk("R6 in ack", int'(hs_ack), 1);
        chk("R6 tx consumed", int'(tx_full), 0);
        chk("R6 pend again", int'(data_pend), 1);
        // status without arming
        tok(2);
        chk("R8 status nack", int'(hs_nack), 1);
        chk("R8 stat irq", int'(stat_irq), 1);
        cpu(3);
        chk("R10 stat irq cleared", int'(stat_irq), 0);
        cpu(1);
        chk("R8 armed", int'(stat_en), 1);
        tok(2);
        chk("R8 status ack", int'(hs_ack), 1);
        chk("R8 disarmed", int'(stat_en), 0);
        chk("R8 idle", int'(stage), 0);

        // preset direction
        setup(1, 7, 0, 0);
        cpu(0);
        chk("R6 preset dir", int'(dir_in), 1);
        cpu(4);
        tok(1);
        chk("R6 first in ack", int'(hs_ack), 1);

        // restart mid-transfer, arm in same cycle as setup
        cpu(1);
        chk("R9 armed before", int'(stat_en), 1);
        @(negedge clk);
        setup_stb = 1; setup_std = 1; setup_req = 8'd6; setup_nodata = 0;
        cpu_stat_enable = 1; cpu_setup_irq_clr = 1;
        @(negedge clk);
        setup_stb = 0; cpu_stat_enable = 0; cpu_setup_irq_clr = 0;
        chk("R9 disarmed", int'(stat_en), 0);
        chk("R9 stage data", int'(stage), 1);
        chk("R9 dir reset", int'(dir_in), 0);
        chk("R10 set wins", int'(setup_irq), 1);

        // no data stage
        setup(0, 3, 0, 1);
        chk("R11 status stage", int'(stage), 2);
        tok(0);
        chk("R11 out nack", int'(hs_nack), 1);
        tok(1);
        chk("R11 in nack", int'(hs_nack), 1);

        // internal request
        cpu(2);
        setup(1, 0, 0, 0);
        chk("R12 auto stage", int'(stage), 3);
        chk("R12 no irq", int'(setup_irq), 0);
        tok(1);
        chk("R12 in ack", int'(hs_ack), 1);
        tok(0);
        chk("R12 out ack", int'(hs_ack), 1);
        tok(2);
        chk("R12 status ack", int'(hs_ack), 1);
        chk("R12 idle", int'(stage), 0);
        @(negedge clk);
        chk("R2 quiet", int'(hs_ack | hs_nack), 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule